// File: doc/BRIEF.md
# SPI Flash Register Transaction Sequencer

This block carries out one register-style transaction on a serial flash device, driven by a single 32-bit request word. The word selects a bank, a command byte and three nibble counts. The counts set how many address bytes follow the command, how many write bytes follow those, and how many bytes are read back. A flag marks the request as a write. When this flag is set, the read-back phase is dropped.

The sequencer drives chip select low, clocks out the command, address and write bytes MSB first, and then releases the data-out line. It holds the serial clock low for a fixed turnaround gap and then clocks in the reply. Reply bits are collected into a 64-bit result mailbox. A one-cycle done pulse ends the transaction. A request aimed at a bank that the bank table marks empty is refused: done and an error flag pulse, and the bus stays quiet.

The serial clock is derived from the system clock by a programmable divider. Input sampling can be direct from the pin or through one extra flop, for faster clocks.

Top module: `spi_reg_seq`

## Requirements
- R1: Request word fields are bank index [3:0], command [11:4], address byte count [15:12], write byte count [19:16], read byte count [23:20] and write flag [24]. The command is always sent first, as 8 bits, MSB first, on `sdo`, and each bit is valid at the rising edge of `sck`.
- R2: After the command, the top `na` bytes of `addr_in` are sent, starting with bits [119:112], MSB first. When `na` is zero, no address bits are sent.
- R3: After the address, the top `nw` bytes of `wr_in` are sent in the same way. When `nw` is zero, no write bits are sent.
- R4: The read byte count is clamped to 8, and a set write flag makes it zero. The received bits are shifted in at bit 0 of `result`, so the reply ends up right-justified, and all higher bits are zero. `result` is cleared when a request is accepted.
- R5: When `bank_ok[bank]` is 0, `done` and `err` are high together for one cycle, starting in the cycle after `start`. In that case `cs_n` never goes low and `sck` never toggles.
- R6: `cs_n` goes low in the cycle after an accepted `start`. It rises only after `sck` has been low for at least one cycle following the last clock. At that point `done` pulses for one cycle while `cs_n` is high.
- R7: When the read count is nonzero, `sdo_oe` drops after the last transmit bit, and `sck` stays low for `TURN_GAP` cycles before the read clocks start. When the read count is zero, there is no gap. Chip select is low for D·(8+8·na+8·nw) + (rn>0 ? TURN_GAP + D·rn : 0) + 1 cycles, where rn is the number of read bits.
- R8: Each serial bit lasts D = max(`clk_div`, 2) system cycles. `sck` is low for the first floor(D/2) of those cycles and high for the rest.
- R9: With `reg_in` set, sampling goes through one extra flop. The bits received are the same as with direct sampling.
- R10: A `start` that arrives while a transaction is in progress is ignored.
- R11: While idle, and out of reset, `cs_n` is high, and `sck`, `sdo_oe` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, taken only when idle |
| req | input | 32 | Request word |
| addr_in | input | 120 | Address bytes, first byte in the top bits |
| wr_in | input | 120 | Write bytes, first byte in the top bits |
| bank_ok | input | 16 | Bank table, one valid bit per bank |
| clk_div | input | DIVW | System cycles per serial bit (minimum 2) |
| reg_in | input | 1 | Selects registered input sampling |
| sdi | input | 1 | Serial data from the flash |
| cs_n | output | 1 | Chip select, active low |
| sck | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data to the flash |
| sdo_oe | output | 1 | Output enable for `sdo` |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | Empty-bank error, valid with `done` |
| result | output | 64 | Read-back mailbox |

## Verification
The bench targets several corner cases.
- **Zero counts.** A design that mishandles a zero count would emit stray address or write bytes.
- **Read clamp.** A read count above 8 checks the clamp. Without it, the clock would run past 64 bits and the length would grow.
- **Write flag.** Setting the write flag while a read count is given checks that the read phase and the turnaround gap are both dropped.
- **Divider.** Divider values 0, 1 and odd values test the clamp and the uneven high and low split of the clock. Errors show up as a wrong chip-select length or misread bits.
- **Sampling modes.** Registered sampling at the fastest divider would lose or shift the final reply bit if its capture were not carried through the tail cycle.
- **Busy and empty bank.** A `start` sent during a busy transaction must leave the bus silent afterwards. An empty bank must produce the error pulse with no chip-select activity.

// File: rtl/spi_reg_seq.sv
module spi_reg_seq #(
  parameter int TURN_GAP = 5,
  parameter int DIVW     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [31:0]         req,
  input  logic [119:0]        addr_in,
  input  logic [119:0]        wr_in,
  input  logic [15:0]         bank_ok,
  input  logic [DIVW-1:0]     clk_div,
  input  logic                reg_in,
  input  logic                sdi,
  output logic                cs_n,
  output logic                sck,
  output logic                sdo,
  output logic                sdo_oe,
  output logic                done,
  output logic                err,
  output logic [63:0]         result
);
  localparam int GW = $clog2(TURN_GAP + 1);

  typedef enum logic [2:0] {IDLE, TX, GAP, RX, TAIL} st_t;
  st_t st;

  logic [DIVW-1:0] div_q, ph;
  logic [7:0]      left, wr_left, rx_bits;
  logic [GW-1:0]   gcnt;
  logic [127:0]    sr;
  logic            sdi_q, samp_d, reg_q;

  wire [3:0] bank = req[3:0];
  wire [7:0] cmd  = req[11:4];
  wire [3:0] na   = req[15:12];
  wire [3:0] nw   = req[19:16];
  wire [3:0] nr   = req[23:20];
  wire       wfl  = req[24];

  wire [3:0]      rd_cnt  = (nr > 4'd8) ? 4'd8 : nr;
  wire [7:0]      rx_init = wfl ? 8'd0 : {1'b0, rd_cnt, 3'b000};
  wire [DIVW-1:0] div_eff = (clk_div < DIVW'(2)) ? DIVW'(2) : clk_div;
  wire [DIVW-1:0] half    = div_q >> 1;
  wire            bit_end = (ph == div_q - DIVW'(1));

  assign cs_n   = (st == IDLE);
  assign sck    = (st == TX || st == RX) && (ph >= half);
  assign sdo    = (st == TX) && sr[127];
  assign sdo_oe = (st == TX);

  wire samp_p = (st == RX) && (ph == half);
  wire cap    = reg_q ? samp_d : samp_p;
  wire cbit   = reg_q ? sdi_q : sdi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; div_q <= DIVW'(2); ph <= '0; left <= '0; wr_left <= '0;
      rx_bits <= '0; gcnt <= '0; sr <= '0; sdi_q <= 1'b0; samp_d <= 1'b0;
      reg_q <= 1'b0; done <= 1'b0; err <= 1'b0; result <= '0;
    end else begin
      done   <= 1'b0;
      err    <= 1'b0;
      sdi_q  <= sdi;
      samp_d <= samp_p;
      if (cap) result <= {result[62:0], cbit};
      case (st)
        IDLE: if (start) begin
          result <= '0;
          if (!bank_ok[bank]) begin
            done <= 1'b1;
            err  <= 1'b1;
          end else begin
            st      <= TX;
            ph      <= '0;
            div_q   <= div_eff;
            reg_q   <= reg_in;
            sr      <= {cmd, addr_in};
            left    <= 8'd8 + {1'b0, na, 3'b000};
            wr_left <= {1'b0, nw, 3'b000};
            rx_bits <= rx_init;
          end
        end
        TX: if (bit_end) begin
          ph <= '0;
          if (left > 8'd1) begin
            left <= left - 8'd1;
            sr   <= {sr[126:0], 1'b0};
          end else if (wr_left != 8'd0) begin
            left    <= wr_left;
            wr_left <= 8'd0;
            sr      <= {wr_in, 8'h00};
          end else if (rx_bits != 8'd0) begin
            st   <= GAP;
            gcnt <= '0;
          end else begin
            st <= TAIL;
          end
        end else begin
          ph <= ph + DIVW'(1);
        end
        GAP: if (gcnt == GW'(TURN_GAP - 1)) begin
          st   <= RX;
          ph   <= '0;
          left <= rx_bits;
        end else begin
          gcnt <= gcnt + GW'(1);
        end
        RX: if (bit_end) begin
          ph <= '0;
          if (left > 8'd1) left <= left - 8'd1;
          else             st   <= TAIL;
        end else begin
          ph <= ph + DIVW'(1);
        end
        TAIL: begin
          st   <= IDLE;
          done <= 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_reg_seq_chk.sv
module spi_reg_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck,
  input logic sdo_oe,
  input logic done,
  input logic err
);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!sck && !sdo_oe));

  // R5
  err_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && cs_n && $past(cs_n)));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> !$past(sck));

  // R7
  turn_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sdo_oe) && !cs_n) |-> !sck);

  // R6
  done_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cs_n);
endmodule

bind spi_reg_seq spi_reg_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
  .sdo_oe(sdo_oe), .done(done), .err(err)
);

// File: tb/test_spi_reg_seq.sv
`timescale 1ns/1ps
module test_spi_reg_seq;
  localparam int TG = 5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, reg_in = 1'b0;
  logic [31:0]  req = '0;
  logic [119:0] addr_in = '0, wr_in = '0;
  logic [15:0]  bank_ok = 16'hBEEF;
  logic [3:0]   clk_div = 4'd2;
  logic         sdi;
  logic cs_n, sck, sdo, sdo_oe, done, err;
  logic [63:0] result;
  logic [63:0] resp = '0;

  int n_run = 0, n_fail = 0;
  int rr = 0, rf = 0, txn = 0, cslow = 0;
  logic [255:0] txlog = '0;

  spi_reg_seq i_spi_reg_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .req(req), .addr_in(addr_in),
    .wr_in(wr_in), .bank_ok(bank_ok), .clk_div(clk_div), .reg_in(reg_in),
    .sdi(sdi), .cs_n(cs_n), .sck(sck), .sdo(sdo), .sdo_oe(sdo_oe),
    .done(done), .err(err), .result(result)
  );

  always #4 clk = ~clk;

  assign sdi = (rf < 64) ? resp[63 - rf] : 1'b0;
  always @(posedge sck) if (!cs_n && !sdo_oe) rr = rr + 1;
  always @(negedge sck) rf = rr;
  always @(posedge sck) if (sdo_oe) begin txlog = {txlog[254:0], sdo}; txn = txn + 1; end
  always @(posedge clk) if (!cs_n) cslow = cslow + 1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic txn_run(input logic [3:0] bank, input logic [7:0] cmd,
                         input logic [3:0] na, input logic [3:0] nw,
                         input logic [3:0] nr, input bit wf,
                         input logic [3:0] div, input bit rg, input bit poke);
    logic [255:0] e = '0;
    int n, rn, d, elen, guard, held;
    logic [63:0] er;
    bit valid = bank_ok[bank];
    @(negedge clk);
    req = {7'd0, wf, nr, nw, na, cmd, bank};
    clk_div = div; reg_in = rg;
    resp = {$urandom, $urandom};
    rr = 0; rf = 0; txn = 0; cslow = 0; txlog = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      req = {7'd0, 1'b0, 4'd8, 4'd2, 4'd2, 8'hA5, bank};
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 5000) begin @(negedge clk); guard++; end
    if (guard >= 5000) begin
      chk(0, "R6", "watchdog waiting for done", 0, 1);
      return;
    end
    for (int i = 0; i < 8; i++) e = {e[254:0], cmd[7-i]};
    for (int b = 0; b < int'(na); b++)
      for (int i = 0; i < 8; i++) e = {e[254:0], addr_in[119 - 8*b - i]};
    for (int b = 0; b < int'(nw); b++)
      for (int i = 0; i < 8; i++) e = {e[254:0], wr_in[119 - 8*b - i]};
    n  = 8 + 8*int'(na) + 8*int'(nw);
    rn = wf ? 0 : 8 * ((nr > 4'd8) ? 8 : int'(nr));
    er = (rn == 0) ? 64'd0 : (resp >> (64 - rn));
    d  = (div < 4'd2) ? 2 : int'(div);
    elen = d*n + ((rn > 0) ? (TG + d*rn) : 0) + 1;
    chk(cs_n === 1'b1, "R6", "cs_n high at done", 256'(cs_n), 1);
    if (!valid) begin
      chk(err === 1'b1, "R5", "err on empty bank", 256'(err), 1);
      chk(cslow == 0 && txn == 0, "R5", "bus activity on empty bank", 256'(cslow + txn), 0);
    end else begin
      chk(err === 1'b0, "R5", "err on valid bank", 256'(err), 0);
      chk(txn == n, "R1/R2/R3", "tx bit count", 256'(txn), 256'(n));
      chk(txlog == e, "R1/R2/R3", "tx bit stream", txlog, e);
      chk(result === er, "R4/R9", "result mailbox", 256'(result), 256'(er));
      chk(cslow == elen, "R7/R8", "cs low length", 256'(cslow), 256'(elen));
    end
    if (poke) begin
      held = cslow;
      repeat (20) @(negedge clk);
      chk(cslow == held, "R10", "busy start caused new activity", 256'(cslow), 256'(held));
    end
  endtask

  initial begin
    bit vv;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sck === 1'b0 && sdo_oe === 1'b0 && done === 1'b0,
        "R11", "reset outputs", {cs_n, sck, sdo_oe, done}, 4'b1000);
    chk(result === 64'd0, "R11", "reset result", 256'(result), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n === 1'b1 && sck === 1'b0, "R11", "idle after reset", {cs_n, sck}, 2'b10);

    addr_in = {$urandom, $urandom, $urandom, $urandom};
    wr_in   = {$urandom, $urandom, $urandom, $urandom};
    // R1 command only
    txn_run(4'd0, 8'h9F, 4'd0, 4'd0, 4'd0, 1'b0, 4'd2, 1'b0, 1'b0);
    // R2 R4 address then read
    txn_run(4'd1, 8'h0B, 4'd3, 4'd0, 4'd2, 1'b0, 4'd2, 1'b0, 1'b0);
    // R3 maximum address and write
    txn_run(4'd2, 8'h02, 4'd15, 4'd15, 4'd0, 1'b0, 4'd2, 1'b0, 1'b0);
    // R4 read clamp
    txn_run(4'd3, 8'h5A, 4'd0, 4'd0, 4'd15, 1'b0, 4'd3, 1'b0, 1'b0);
    // R4 R7 write flag suppresses read and gap
    txn_run(4'd0, 8'h01, 4'd1, 4'd2, 4'd4, 1'b1, 4'd2, 1'b0, 1'b0);
    // R5 empty bank (bit 4 of 16'hBEEF is 0)
    txn_run(4'd4, 8'h05, 4'd1, 4'd1, 4'd1, 1'b0, 4'd2, 1'b0, 1'b0);
    // R8 divider clamp
    txn_run(4'd1, 8'hC3, 4'd1, 4'd0, 4'd1, 1'b0, 4'd0, 1'b0, 1'b0);
    txn_run(4'd1, 8'h3C, 4'd0, 4'd1, 4'd1, 1'b0, 4'd1, 1'b0, 1'b0);
    // R9 registered sampling at fastest and slow divider
    txn_run(4'd2, 8'h05, 4'd0, 4'd0, 4'd8, 1'b0, 4'd2, 1'b1, 1'b0);
    txn_run(4'd2, 8'h35, 4'd1, 4'd0, 4'd3, 1'b0, 4'd5, 1'b1, 1'b0);
    // R10 start while busy
    txn_run(4'd3, 8'hAB, 4'd2, 4'd1, 4'd2, 1'b0, 4'd3, 1'b0, 1'b1);

    for (int k = 0; k < 40; k++) begin
      addr_in = {$urandom, $urandom, $urandom, $urandom};
      wr_in   = {$urandom, $urandom, $urandom, $urandom};
      vv = ($urandom % 8) == 0;
      txn_run(4'($urandom), 8'($urandom), 4'($urandom % 5), 4'($urandom % 5),
              4'($urandom), vv, 4'($urandom % 6), 1'($urandom), 1'($urandom % 6 == 0));
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule